// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This controller takes a programmable logic device from power-on to user operation. Once the power-on reset is released it times an initialization delay and then a configuration-memory clear. It then waits for the external reset to go inactive and samples the three mode pins. After that it stays in a configuration phase until the loader reports success or a fault. When configuration completes, the controller passes through a single start-up cycle and then releases the user I/O.

Both delays are counted in ticks of a slow internal timer, which reaches the block as a one-clock `tick_i` pulse. Master modes, where the device drives the configuration clock, stretch the initialization delay fourfold. This gives any devices daisy-chained behind a master time to finish their own initialization. A reset held through three consecutive timer ticks during configuration aborts back to the clear phase. A stop-bit framing error ends configuration in a fault state that holds until power-on reset.

Top module: `cfg_seq_top`

## Requirements
- R1: While and after `rst_n` (power-on reset) is low, `state_o` is 0 (initialization), `init_n_o` is 0, `io_tristate_o` is 1 and `cclk_master_o` is 0. State codes: 0 init, 1 clear, 2 wait, 3 configure, 4 start-up, 5 operational, 6 power-down, 7 fault.
- R2: For a non-master mode, initialization lasts exactly 2^INIT_BITS ticks. The state becomes 1 on the clock edge that carries the last of those ticks.
- R3: Master modes use a `mode_i` value of 000, 010 or 011. For these, initialization lasts 2^(INIT_BITS+2) ticks, which is four times the non-master length.
- R4: `pwrdn_req_i` has no effect during initialization. The state stays 0 and the I/O stay 3-stated.
- R5: The clear phase lasts exactly CLEAR_TICKS ticks. `clear_strobe_o` is high in the cycle of each tick within the phase, and `init_n_o` stays low throughout.
- R6: `init_n_o` goes high when the clear phase ends and the wait state (2) is entered.
- R7: In the wait state, the controller stays put while `ext_reset_n_i` is low. Once it is high and the mode is supported, the next edge moves to the configure state (3) and captures `mode_i`.
- R8: The reserved mode codes 001, 100 and 110 keep the controller in the wait state with `mode_err_o` high.
- R9: During configuration, `ext_reset_n_i` low at ABORT_TICKS consecutive ticks aborts to the clear state. A tick that sees the reset high restarts the count, so a shorter reset has no effect.
- R10: `frame_err_i` during configuration enters the fault state (7). There `init_n_o` is low and the controller stays until power-on reset.
- R11: `cclk_master_o` is 1 when the most recently captured mode is anything other than 111 (slave). For slave mode it is 0.
- R12: `cfg_done_i` during configuration gives exactly one cycle of the start-up state (4), then the operational state (5). `io_tristate_o` is 0 only in state 5.
- R13: `pwrdn_req_i` in the operational state enters power-down (6), which 3-states the I/O. The controller returns to state 5 on the edge after the request is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ext_reset_n_i | input | 1 | External reset, active low |
| pwrdn_req_i | input | 1 | Power-down request |
| mode_i | input | 3 | Mode pins |
| tick_i | input | 1 | One-clock pulse per internal timer cycle |
| frame_err_i | input | 1 | Stop-bit framing error from the loader |
| cfg_done_i | input | 1 | Configuration complete from the loader |
| init_n_o | output | 1 | Active-low initialization/fault indicator |
| io_tristate_o | output | 1 | 3-state enable for user I/O |
| cclk_master_o | output | 1 | 1 = drive configuration clock, 0 = receive it |
| clear_strobe_o | output | 1 | Clear-memory strobe, one per tick in the clear phase |
| mode_err_o | output | 1 | Unsupported mode code seen in the wait state |
| state_o | output | 3 | Current state code |

## Verification
The abort path is the hardest to reach from the ports. The bench must first pass through initialization, clear and a valid mode sample. It must then hold the external reset low across exactly the right number of ticks, and interrupt a shorter run to show that the count restarts. The stimulus drives a small configuration (8-tick init, 5-tick clear) tick by tick, and checks the state after every tick near each boundary. It then sweeps all eight mode codes from power-on, with the expected delay computed from the mode.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_WAIT  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_START = 3'd4,
    ST_RUN   = 3'd5,
    ST_SLEEP = 3'd6,
    ST_FAULT = 3'd7
  } cfg_state_e;

  localparam logic [2:0] MODE_SLAVE = 3'b111;

  function automatic logic mode_is_master(input logic [2:0] m);
    return (m == 3'b000) || (m == 3'b010) || (m == 3'b011);
  endfunction

  function automatic logic mode_is_reserved(input logic [2:0] m);
    return (m == 3'b001) || (m == 3'b100) || (m == 3'b110);
  endfunction

endpackage

// File: rtl/cfg_delay_ctr.sv
module cfg_delay_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // Both delay limits fit the counter, so a counted tick never wraps it.
  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && !clr_i && (cnt_q == {W{1'b1}})));

endmodule

// File: rtl/cfg_abort_filter.sv
module cfg_abort_filter #(
  parameter int N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic tick_i,
  input  logic reset_n_i,
  output logic abort_o
);

  localparam int CW = (N < 2) ? 1 : $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;

  always_comb begin
    run_d = run_q;
    if (!arm_i)         run_d = '0;
    else if (tick_i) begin
      if (reset_n_i)    run_d = '0;
      else if (run_q != LAST) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign abort_o = arm_i && tick_i && !reset_n_i && (run_q == LAST);

  // The run count never goes past the abort threshold.
  assert_run_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LAST);

  // A tick that sees the reset released leaves the count at zero.
  assert_run_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && tick_i && reset_n_i) |=> (run_q == '0));

endmodule

// File: rtl/cfg_mode_reg.sv
module cfg_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [2:0] mode_i,
  output logic       master_o,
  output logic       cclk_out_o
);

  import cfg_seq_pkg::*;

  logic [2:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_SLAVE;
    else if (load_i) mode_q <= mode_i;
  end

  assign master_o   = mode_is_master(mode_q);
  assign cclk_out_o = (mode_q != MODE_SLAVE);

endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top #(
  parameter int INIT_BITS   = 14,
  parameter int CLEAR_TICKS = 250,
  parameter int ABORT_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_reset_n_i,
  input  logic       pwrdn_req_i,
  input  logic [2:0] mode_i,
  input  logic       tick_i,
  input  logic       frame_err_i,
  input  logic       cfg_done_i,
  output logic       init_n_o,
  output logic       io_tristate_o,
  output logic       cclk_master_o,
  output logic       clear_strobe_o,
  output logic       mode_err_o,
  output logic [2:0] state_o
);

  import cfg_seq_pkg::*;

  localparam int LONG_BITS = INIT_BITS + 2;
  localparam int CLR_BITS  = $clog2(CLEAR_TICKS + 1);
  localparam int CW        = (LONG_BITS > CLR_BITS) ? LONG_BITS : CLR_BITS;
  localparam logic [CW-1:0] SHORT_LAST = CW'((64'd1 << INIT_BITS) - 64'd1);
  localparam logic [CW-1:0] LONG_LAST  = CW'((64'd1 << LONG_BITS) - 64'd1);
  localparam logic [CW-1:0] CLEAR_LAST = CW'(CLEAR_TICKS - 1);

  cfg_state_e    state_q, state_d;
  logic [CW-1:0] cnt;
  logic          cnt_en, cnt_clr;
  logic          is_master;
  logic          init_done, clear_done, abort;
  logic          mode_load;

  // Delay counter shared by initialization and clear phases
  assign cnt_en  = tick_i && ((state_q == ST_INIT) || (state_q == ST_CLEAR));
  assign cnt_clr = (state_d != state_q);

  cfg_delay_ctr #(.W(CW)) delay_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  cfg_abort_filter #(.N(ABORT_TICKS)) abort_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (state_q == ST_LOAD),
    .tick_i    (tick_i),
    .reset_n_i (ext_reset_n_i),
    .abort_o   (abort)
  );

  assign mode_load = (state_q == ST_INIT) ||
                     ((state_q == ST_WAIT) && (state_d == ST_LOAD));

  cfg_mode_reg mode_i_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (mode_load),
    .mode_i     (mode_i),
    .master_o   (is_master),
    .cclk_out_o (cclk_master_o)
  );

  assign init_done  = tick_i && (cnt == (is_master ? LONG_LAST : SHORT_LAST));
  assign clear_done = tick_i && (cnt == CLEAR_LAST);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:  if (init_done)  state_d = ST_CLEAR;
      ST_CLEAR: if (clear_done) state_d = ST_WAIT;
      ST_WAIT:  if (ext_reset_n_i && !mode_is_reserved(mode_i)) state_d = ST_LOAD;
      ST_LOAD: begin
        if (frame_err_i)     state_d = ST_FAULT;
        else if (abort)      state_d = ST_CLEAR;
        else if (cfg_done_i) state_d = ST_START;
      end
      ST_START: state_d = ST_RUN;
      ST_RUN:   if (pwrdn_req_i)  state_d = ST_SLEEP;
      ST_SLEEP: if (!pwrdn_req_i) state_d = ST_RUN;
      ST_FAULT: state_d = ST_FAULT;
      default:  state_d = ST_INIT;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  assign state_o        = state_q;
  assign init_n_o       = !((state_q == ST_INIT) || (state_q == ST_CLEAR) ||
                            (state_q == ST_FAULT));
  assign io_tristate_o  = (state_q != ST_RUN);
  assign clear_strobe_o = (state_q == ST_CLEAR) && tick_i;
  assign mode_err_o     = (state_q == ST_WAIT) && mode_is_reserved(mode_i);

  // Initialization ends only on a timer tick.
  assert_init_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR && $past(state_q) == ST_INIT) |-> $past(tick_i));

  // Power-down requests cannot pull the controller out of initialization.
  assert_init_no_pwrdn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT) |=> (state_q == ST_INIT || state_q == ST_CLEAR));

  // Configuration starts only with reset released and a supported mode.
  assert_load_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && $past(state_q) == ST_WAIT)
      |-> ($past(ext_reset_n_i) && !mode_is_reserved($past(mode_i))));

  // An abort to clear follows a tick seen with reset asserted.
  assert_abort_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLEAR && $past(state_q) == ST_LOAD)
      |-> ($past(tick_i) && !$past(ext_reset_n_i)));

  // The fault state holds until power-on reset.
  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT) |=> (state_q == ST_FAULT));

  // Start-up lasts a single cycle.
  assert_startup_one_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |=> (state_q == ST_RUN));

  // Leaving power-down requires the request to be removed.
  assert_sleep_exit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_SLEEP) |-> !$past(pwrdn_req_i));

endmodule

// File: tb/cfg_seq_top_tb_top.sv
module cfg_seq_top_tb_top;

  localparam int INIT_BITS   = 3;
  localparam int CLEAR_TICKS = 5;
  localparam int ABORT_TICKS = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_reset_n;
  logic       pwrdn_req;
  logic [2:0] mode;
  logic       tick;
  logic       frame_err;
  logic       cfg_done;
  logic       init_n, io_tri, cclk_m, clr_stb, mode_err;
  logic [2:0] state;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  cfg_seq_top #(
    .INIT_BITS   (INIT_BITS),
    .CLEAR_TICKS (CLEAR_TICKS),
    .ABORT_TICKS (ABORT_TICKS)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_reset_n_i  (ext_reset_n),
    .pwrdn_req_i    (pwrdn_req),
    .mode_i         (mode),
    .tick_i         (tick),
    .frame_err_i    (frame_err),
    .cfg_done_i     (cfg_done),
    .init_n_o       (init_n),
    .io_tristate_o  (io_tri),
    .cclk_master_o  (cclk_m),
    .clear_strobe_o (clr_stb),
    .mode_err_o     (mode_err),
    .state_o        (state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clk1();
    @(negedge clk);
  endtask

  task automatic tick1();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic por(input logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; tick = 1'b0; frame_err = 1'b0;
    cfg_done = 1'b0; pwrdn_req = 1'b0;
    clk1();
    rst_n = 1'b1;
    clk1();
  endtask

  function automatic int init_len(input logic [2:0] m);
    if (m == 3'b000 || m == 3'b010 || m == 3'b011) return 1 << (INIT_BITS + 2);
    return 1 << INIT_BITS;
  endfunction

  function automatic bit reserved(input logic [2:0] m);
    return (m == 3'b001) || (m == 3'b100) || (m == 3'b110);
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int strobes;
    rst_n = 1'b0; ext_reset_n = 1'b1; pwrdn_req = 1'b0; mode = 3'b101;
    tick = 1'b0; frame_err = 1'b0; cfg_done = 1'b0;
    repeat (2) clk1();
    // R1: reset state
    chk("R1 state", state, 0);
    chk("R1 init_n", init_n, 0);
    chk("R1 io_tri", io_tri, 1);
    chk("R1 cclk", cclk_m, 0);
    rst_n = 1'b1;
    clk1();
    chk("R11 cclk peripheral", cclk_m, 1);
    // R4: power-down ignored in initialization
    pwrdn_req = 1'b1;
    ticks(3);
    chk("R4 state", state, 0);
    chk("R4 io_tri", io_tri, 1);
    pwrdn_req = 1'b0;
    // R2: non-master init length 8
    ticks(init_len(3'b101) - 4);
    chk("R2 before end", state, 0);
    ext_reset_n = 1'b0;
    tick1();
    chk("R2 at end", state, 1);
    // R5: clear phase
    strobes = 0;
    for (int i = 0; i < CLEAR_TICKS; i++) begin
      @(negedge clk) tick = 1'b1;
      #1 strobes += clr_stb;
      if (i < CLEAR_TICKS - 1) begin
        @(negedge clk) tick = 1'b0;
        if (i == CLEAR_TICKS - 2) begin
          chk("R5 still clear", state, 1);
          chk("R5 init_n low", init_n, 0);
        end
      end else begin
        @(negedge clk) tick = 1'b0;
      end
    end
    chk("R5 strobes", strobes, CLEAR_TICKS);
    chk("R5 enters wait", state, 2);
    chk("R6 init_n released", init_n, 1);
    // R7: hold in wait while reset low
    repeat (3) clk1();
    chk("R7 held by reset", state, 2);
    // R8: reserved mode
    mode = 3'b001; ext_reset_n = 1'b1;
    repeat (2) clk1();
    chk("R8 stays wait", state, 2);
    chk("R8 mode_err", mode_err, 1);
    // R7/R11: slave mode captured
    mode = 3'b111;
    clk1();
    chk("R7 enters configure", state, 3);
    chk("R11 cclk slave", cclk_m, 0);
    mode = 3'b000;
    clk1();
    chk("R7 mode captured once", cclk_m, 0);
    // R9: interrupted reset does not abort
    ext_reset_n = 1'b0;
    ticks(ABORT_TICKS - 1);
    ext_reset_n = 1'b1;
    tick1();
    ext_reset_n = 1'b0;
    ticks(ABORT_TICKS - 1);
    chk("R9 no abort short", state, 3);
    tick1();
    chk("R9 abort", state, 1);
    ext_reset_n = 1'b1;
    ticks(CLEAR_TICKS);
    chk("R9 back to wait", state, 2);
    clk1();
    chk("R9 reconfigure", state, 3);
    chk("R11 cclk master resampled", cclk_m, 1);
    // R12: start-up and operational
    cfg_done = 1'b1;
    clk1();
    cfg_done = 1'b0;
    chk("R12 startup", state, 4);
    chk("R12 io still 3-state", io_tri, 1);
    clk1();
    chk("R12 operational", state, 5);
    chk("R12 io released", io_tri, 0);
    // R13: power-down
    pwrdn_req = 1'b1;
    clk1();
    chk("R13 power-down", state, 6);
    chk("R13 io 3-state", io_tri, 1);
    clk1();
    chk("R13 held", state, 6);
    pwrdn_req = 1'b0;
    clk1();
    chk("R13 resume", state, 5);
    chk("R13 io released", io_tri, 0);
    // R10: framing error fault
    por(3'b111);
    ext_reset_n = 1'b1;
    ticks(init_len(3'b111) + CLEAR_TICKS);
    clk1();
    chk("R10 configuring", state, 3);
    frame_err = 1'b1;
    clk1();
    frame_err = 1'b0;
    chk("R10 fault", state, 7);
    chk("R10 init_n low", init_n, 0);
    cfg_done = 1'b1;
    ticks(4);
    cfg_done = 1'b0;
    chk("R10 sticky", state, 7);
    // R2/R3/R8/R11: sweep every mode code from power-on
    for (int m = 0; m < 8; m++) begin
      int len;
      len = init_len(3'(m));
      ext_reset_n = 1'b0;
      por(3'(m));
      ticks(len - 1);
      chk(len > 8 ? "R3 sweep before end" : "R2 sweep before end", state, 0);
      tick1();
      chk(len > 8 ? "R3 sweep at end" : "R2 sweep at end", state, 1);
      ticks(CLEAR_TICKS);
      ext_reset_n = 1'b1;
      clk1();
      if (reserved(3'(m))) begin
        chk("R8 sweep wait", state, 2);
        chk("R8 sweep mode_err", mode_err, 1);
      end else begin
        chk("R7 sweep configure", state, 3);
        chk("R11 sweep cclk", cclk_m, (m != 7) ? 1 : 0);
      end
    end
    finish_run();
  end

endmodule